// File: doc/BRIEF.md
# Eight-Cell Configurable LUT4 Logic Block

This block is a behavioural, synthesizable model of one logic block from a LUT-based programmable fabric. It holds a row of cells. Each cell has a four-input lookup table, a carry unit that computes a majority, and an optional output flip-flop. A 20-bit word per cell sets the truth table and the cell's modes. The clock, clock enable and set/reset nets are shared by all cells. A single polarity bit selects the active clock edge for every flip-flop in the block.

Cells form a ripple chain. The carry entering cell 0 comes from a small source selector: a force-high bit, or a routed carry from the block below. Each later cell takes the carry out of the cell before it. Two per-cell cascade selects can replace input 3 with the incoming carry and input 2 with the LUT output of the previous cell. The shared clock-enable and set/reset nets each have a "connected" bit. An unconnected enable reads 1 and an unconnected set/reset reads 0. An active-low `rst_n` is the fabric's configuration-time clear.

Top module: `lut4_logic_block`

## Requirements
- R1: While `rst_n` is low, every cell flip-flop is 0, so a cell with its register enabled outputs 0.
- R2: The LUT output for index {in3,in2,in1,in0} = 0..15 is cell word bit 4, 14, 15, 5, 6, 16, 17, 7, 3, 13, 12, 2, 1, 11, 10, 0 respectively.
- R3: With cell word bit 9 set, `cell_out[i]` is the flip-flop. With it clear, `cell_out[i]` is the LUT output with no clock delay.
- R4: The carry out of cell i is 0 when word bit 8 is clear. Otherwise it is the majority of in1, the effective in2, and the carry into cell i. `carry_out` is the carry out of the last cell.
- R5: The carry into cell 0 is `cin_force | (cin_chain_en & cin_from_below)`.
- R6: `i3_from_carry[i]` replaces in3 of cell i with the carry into cell i. `i2_from_prev[i]` (i ≥ 1) replaces in2 with the LUT output of cell i-1. `i2_from_prev[0]` has no effect.
- R7: The effective clock enable is `ce_used ? ce_in : 1`. With it low and no set/reset, the flip-flop holds its value.
- R8: The effective set/reset is `sr_used ? sr_in : 0`. It forces the flip-flop to 1 when word bit 18 is set and to 0 when bit 18 is clear.
- R9: With word bit 19 clear, set/reset acts only on an active clock edge with clock enable high, and it overrides the LUT data.
- R10: With word bit 19 set, set/reset forces the flip-flop at once, whatever the clock or the clock enable.
- R11: With `fall_edge_mode` set, the flip-flops load on the falling edge of `clk` and ignore the rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low clear of all flip-flops |
| fall_edge_mode | input | 1 | Flip-flops use the falling edge when set |
| ce_in | input | 1 | Shared clock-enable net |
| ce_used | input | 1 | Clock-enable net is connected |
| sr_in | input | 1 | Shared set/reset net |
| sr_used | input | 1 | Set/reset net is connected |
| cin_from_below | input | 1 | Carry out of the block below |
| cin_chain_en | input | 1 | Route `cin_from_below` into cell 0 |
| cin_force | input | 1 | Force the cell-0 carry input high |
| lut_i0 | input | NUM_CELLS | LUT input 0, one bit per cell |
| lut_i1 | input | NUM_CELLS | LUT input 1, one bit per cell |
| lut_i2 | input | NUM_CELLS | LUT input 2, one bit per cell |
| lut_i3 | input | NUM_CELLS | LUT input 3, one bit per cell |
| cell_cfg | input | NUM_CELLS*20 | Cell words; cell i occupies bits [20*i+19 : 20*i] |
| i3_from_carry | input | NUM_CELLS | Per-cell select: input 3 from incoming carry |
| i2_from_prev | input | NUM_CELLS | Per-cell select: input 2 from previous LUT |
| cell_out | output | NUM_CELLS | Cell outputs |
| carry_out | output | 1 | Carry out of the last cell |

## Verification
The flip-flop assertions assume two things. First, the set/reset and configuration inputs change only between clock edges. Second, they stay in place long enough for the next active edge to sample them. Reprogramming bit 18 or bit 19 while an asynchronous set/reset is held would leave the register with a stale forced value, so the stimulus never does it. The random phase changes cell words only every 64 vectors, and only on a vector where `sr_in` is low. `fall_edge_mode` is switched only while `rst_n` is low, which prevents the polarity change from making a false clock edge.

// File: rtl/lb_pkg.sv
package lb_pkg;
   localparam int CFG_W       = 20;
   localparam int LUT_ENTRIES = 16;
   localparam int BIT_CARRY   = 8;
   localparam int BIT_REG     = 9;
   localparam int BIT_SETVAL  = 18;
   localparam int BIT_ASYNC   = 19;

   // Position in the cell word that holds truth-table entry idx.
   function automatic int lut_bit(input int idx);
      case (idx)
         0:  return 4;   1:  return 14;  2:  return 15;  3:  return 5;
         4:  return 6;   5:  return 16;  6:  return 17;  7:  return 7;
         8:  return 3;   9:  return 13;  10: return 12;  11: return 2;
         12: return 1;   13: return 11;  14: return 10;  default: return 0;
      endcase
   endfunction
endpackage

// File: rtl/lb_lut4.sv
module lb_lut4
   import lb_pkg::*;
(
   input  logic [CFG_W-1:0] cfg,
   input  logic [3:0]       sel,
   output logic             y
);
   logic [LUT_ENTRIES-1:0] truth;

   // Gather the scattered truth-table bits into index order.
   for (genvar k = 0; k < LUT_ENTRIES; k++) begin : g_truth
      assign truth[k] = cfg[lut_bit(k)];
   end

   assign y = truth[sel];
endmodule

// File: rtl/lb_cell_ff.sv
module lb_cell_ff (
   input  logic clk_act,
   input  logic rst_n,
   input  logic ce,
   input  logic sr,
   input  logic set_val,
   input  logic async_mode,
   input  logic d,
   output logic q
);
   logic sr_async;
   assign sr_async = sr & async_mode;

   always_ff @(posedge clk_act or negedge rst_n or posedge sr_async) begin
      if (!rst_n)        q <= 1'b0;
      else if (sr_async) q <= set_val;
      else if (ce)       q <= sr ? set_val : d;
   end

   // R7: disabled clock enable with no set/reset keeps the stored value
   a_r7_ce_hold: assert property (@(posedge clk_act) disable iff (!rst_n)
      (!ce && !sr) |=> (sr || $stable(q)));

   // R9: synchronous set/reset wins over data at an enabled edge
   a_r9_sync_force: assert property (@(posedge clk_act) disable iff (!rst_n)
      (ce && sr && !async_mode) |=> (q == $past(set_val)));

   // R10: while an asynchronous set/reset is held the register shows the forced value
   a_r10_async_hold: assert property (@(posedge clk_act) disable iff (!rst_n)
      sr_async |-> (q == set_val));
endmodule

// File: rtl/lb_cell.sv
module lb_cell
   import lb_pkg::*;
(
   input  logic             clk_act,
   input  logic             rst_n,
   input  logic [CFG_W-1:0] cfg,
   input  logic             i0,
   input  logic             i1,
   input  logic             i2,
   input  logic             i3,
   input  logic             carry_in,
   input  logic             prev_lut,
   input  logic             use_carry_i3,
   input  logic             use_prev_i2,
   input  logic             ce,
   input  logic             sr,
   output logic             lut_out,
   output logic             carry_nxt,
   output logic             out
);
   logic eff_i2, eff_i3, q;

   assign eff_i3 = use_carry_i3 ? carry_in : i3;
   assign eff_i2 = use_prev_i2  ? prev_lut : i2;

   lb_lut4 u_lut (
      .cfg (cfg),
      .sel ({eff_i3, eff_i2, i1, i0}),
      .y   (lut_out)
   );

   assign carry_nxt = cfg[BIT_CARRY] &
                      ((i1 & eff_i2) | (i1 & carry_in) | (eff_i2 & carry_in));

   lb_cell_ff u_ff (
      .clk_act    (clk_act),
      .rst_n      (rst_n),
      .ce         (ce),
      .sr         (sr),
      .set_val    (cfg[BIT_SETVAL]),
      .async_mode (cfg[BIT_ASYNC]),
      .d          (lut_out),
      .q          (q)
   );

   assign out = cfg[BIT_REG] ? q : lut_out;
endmodule

// File: rtl/lut4_logic_block.sv
module lut4_logic_block
   import lb_pkg::*;
#(
   parameter int NUM_CELLS = 8
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       fall_edge_mode,
   input  logic                       ce_in,
   input  logic                       ce_used,
   input  logic                       sr_in,
   input  logic                       sr_used,
   input  logic                       cin_from_below,
   input  logic                       cin_chain_en,
   input  logic                       cin_force,
   input  logic [NUM_CELLS-1:0]       lut_i0,
   input  logic [NUM_CELLS-1:0]       lut_i1,
   input  logic [NUM_CELLS-1:0]       lut_i2,
   input  logic [NUM_CELLS-1:0]       lut_i3,
   input  logic [NUM_CELLS*CFG_W-1:0] cell_cfg,
   input  logic [NUM_CELLS-1:0]       i3_from_carry,
   input  logic [NUM_CELLS-1:0]       i2_from_prev,
   output logic [NUM_CELLS-1:0]       cell_out,
   output logic                       carry_out
);
   localparam int CHAIN_W = NUM_CELLS + 1;

   if (NUM_CELLS < 1 || NUM_CELLS > 64) begin : g_bad_cells
      $error("lut4_logic_block: NUM_CELLS must lie in 1..64");
   end

   logic                 clk_act, ce_eff, sr_eff;
   logic [CHAIN_W-1:0]   chain;
   logic [NUM_CELLS-1:0] lut_v, cy_en_vec;

   assign clk_act  = clk ^ fall_edge_mode;
   assign ce_eff   = ce_used ? ce_in : 1'b1;
   assign sr_eff   = sr_used & sr_in;
   assign chain[0] = cin_force | (cin_chain_en & cin_from_below);

   for (genvar i = 0; i < NUM_CELLS; i++) begin : g_cell
      logic prev_l, prev_sel;
      if (i == 0) begin : g_head
         assign prev_l   = 1'b0;
         assign prev_sel = 1'b0;
      end else begin : g_body
         assign prev_l   = lut_v[i-1];
         assign prev_sel = i2_from_prev[i];
      end

      assign cy_en_vec[i] = cell_cfg[i*CFG_W + BIT_CARRY];

      lb_cell u_cell (
         .clk_act      (clk_act),
         .rst_n        (rst_n),
         .cfg          (cell_cfg[i*CFG_W +: CFG_W]),
         .i0           (lut_i0[i]),
         .i1           (lut_i1[i]),
         .i2           (lut_i2[i]),
         .i3           (lut_i3[i]),
         .carry_in     (chain[i]),
         .prev_lut     (prev_l),
         .use_carry_i3 (i3_from_carry[i]),
         .use_prev_i2  (prev_sel),
         .ce           (ce_eff),
         .sr           (sr_eff),
         .lut_out      (lut_v[i]),
         .carry_nxt    (chain[i+1]),
         .out          (cell_out[i])
      );
   end

   assign carry_out = chain[NUM_CELLS];

   // R4: all carries enabled with in1 and in2 high everywhere must give a carry out
   a_r4_carry_saturate: assert property (@(posedge clk) disable iff (!rst_n)
      (&cy_en_vec && &lut_i1 && &lut_i2 &&
       ((i2_from_prev & ~NUM_CELLS'(1)) == '0)) |-> carry_out);
endmodule

// File: tb/tb_lut4_logic_block.sv
`timescale 1ns/100ps
module tb_lut4_logic_block;
   localparam int N = 8;
   localparam int W = 20;

   logic clk = 1'b0, rst_n = 1'b0, fall_edge_mode = 1'b0;
   logic ce_in = 1'b0, ce_used = 1'b0, sr_in = 1'b0, sr_used = 1'b0;
   logic cin_from_below = 1'b0, cin_chain_en = 1'b0, cin_force = 1'b0;
   logic [N-1:0] lut_i0 = '0, lut_i1 = '0, lut_i2 = '0, lut_i3 = '0;
   logic [N-1:0] i3_from_carry = '0, i2_from_prev = '0;
   logic [N*W-1:0] cell_cfg = '0;
   logic [N-1:0] cell_out;
   logic carry_out;

   logic [N-1:0] mq = '0, exp_lut, exp_out;
   logic exp_cout;
   int n_chk = 0, n_bad = 0;

   always #2 clk = ~clk;

   lut4_logic_block #(.NUM_CELLS(N)) dut (
      .clk(clk), .rst_n(rst_n), .fall_edge_mode(fall_edge_mode),
      .ce_in(ce_in), .ce_used(ce_used), .sr_in(sr_in), .sr_used(sr_used),
      .cin_from_below(cin_from_below), .cin_chain_en(cin_chain_en), .cin_force(cin_force),
      .lut_i0(lut_i0), .lut_i1(lut_i1), .lut_i2(lut_i2), .lut_i3(lut_i3),
      .cell_cfg(cell_cfg), .i3_from_carry(i3_from_carry), .i2_from_prev(i2_from_prev),
      .cell_out(cell_out), .carry_out(carry_out)
   );

   // R2 ordering of truth-table bits
   function automatic int tt_pos(input logic [3:0] idx);
      int t [16] = '{4, 14, 15, 5, 6, 16, 17, 7, 3, 13, 12, 2, 1, 11, 10, 0};
      return t[idx];
   endfunction

   function automatic logic [W-1:0] mk(input logic ones, input logic reg_en,
                                       input logic setv, input logic asy);
      logic [W-1:0] w;
      w = ones ? 20'h3FCFF : 20'h0;
      w[9] = reg_en; w[18] = setv; w[19] = asy;
      return w;
   endfunction

   task automatic fill_cfg(input logic [W-1:0] w);
      for (int i = 0; i < N; i++) cell_cfg[i*W +: W] = w;
   endtask

   task automatic model_comb();
      logic c, a2, a3;
      c = cin_force | (cin_chain_en & cin_from_below);
      for (int i = 0; i < N; i++) begin
         a3 = i3_from_carry[i] ? c : lut_i3[i];
         a2 = (i > 0 && i2_from_prev[i]) ? exp_lut[i-1] : lut_i2[i];
         exp_lut[i] = cell_cfg[i*W + tt_pos({a3, a2, lut_i1[i], lut_i0[i]})];
         c = cell_cfg[i*W + 8] ? ((lut_i1[i] & a2) | (lut_i1[i] & c) | (a2 & c)) : 1'b0;
         exp_out[i] = cell_cfg[i*W + 9] ? mq[i] : exp_lut[i];
      end
      exp_cout = c;
   endtask

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] expv);
      n_chk++;
      if (act !== expv) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h at %0t", tag, act, expv, $time);
      end
   endtask

   // Inputs were just assigned away from any edge; compare, then pass the active edge.
   task automatic step(input string tag);
      logic ce_e, sr_e;
      ce_e = ce_used ? ce_in : 1'b1;
      sr_e = sr_used & sr_in;
      for (int i = 0; i < N; i++) begin
         if (!rst_n) mq[i] = 1'b0;
         else if (sr_e && cell_cfg[i*W + 19]) mq[i] = cell_cfg[i*W + 18];
      end
      #0.5;
      model_comb();
      check({tag, " cell_out"}, 32'(cell_out), 32'(exp_out));
      check({tag, " carry_out"}, 32'(carry_out), 32'(exp_cout));
      if (rst_n && ce_e)
         for (int i = 0; i < N; i++) mq[i] = sr_e ? cell_cfg[i*W + 18] : exp_lut[i];
      if (fall_edge_mode) @(negedge clk); else @(posedge clk);
      #1;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      #1;
      // R1: reset clears registers
      fill_cfg(mk(1, 1, 0, 0));
      step("R1 reset");
      check("R1 reset out", 32'(cell_out), 32'h0);
      rst_n = 1'b0; step("R1 reset hold");
      rst_n = 1'b1; ce_used = 1'b1; ce_in = 1'b0;

      // R2: every truth-table index against its word bit
      for (int k = 0; k < 16; k++) begin
         logic [3:0] ix; logic [W-1:0] w;
         ix = 4'(k);
         lut_i0 = {N{ix[0]}}; lut_i1 = {N{ix[1]}}; lut_i2 = {N{ix[2]}}; lut_i3 = {N{ix[3]}};
         fill_cfg(20'h1 << tt_pos(ix));
         step("R2 lut one");
         check("R2 lut selected bit", 32'(cell_out), 32'hFF);
         w = 20'hFFFFF & ~(20'h1 << tt_pos(ix));
         w[8] = 1'b0; w[9] = 1'b0; w[18] = 1'b0; w[19] = 1'b0;
         fill_cfg(w);
         step("R2 lut zero");
         check("R2 lut other bits", 32'(cell_out), 32'h0);
      end

      // R4 / R5: carry chain
      fill_cfg(20'h100);
      lut_i0 = '0; lut_i3 = '0; lut_i1 = '1; lut_i2 = '1;
      step("R4 gen"); check("R4 carry generate", 32'(carry_out), 32'h1);
      lut_i1 = '0;
      step("R4 kill"); check("R4 carry none", 32'(carry_out), 32'h0);
      cin_force = 1'b1;
      step("R5 force"); check("R5 forced carry in", 32'(carry_out), 32'h1);
      cell_cfg[3*W + 8] = 1'b0;
      step("R4 disabled"); check("R4 carry disable breaks chain", 32'(carry_out), 32'h0);
      cell_cfg[3*W + 8] = 1'b1;
      cin_force = 1'b0; cin_from_below = 1'b1;
      step("R5 unrouted"); check("R5 unrouted carry in", 32'(carry_out), 32'h0);
      cin_chain_en = 1'b1;
      step("R5 routed"); check("R5 routed carry in", 32'(carry_out), 32'h1);

      // R6: cascades
      fill_cfg(20'h102);
      i3_from_carry = '1;
      step("R6 carry to in3"); check("R6 in3 from carry", 32'(cell_out), 32'hFF);
      i3_from_carry = '0;
      step("R6 pin in3"); check("R6 in3 from pin", 32'(cell_out), 32'h0);
      cin_chain_en = 1'b0; cin_from_below = 1'b0;
      fill_cfg(20'h10);
      lut_i2 = 8'h01; i2_from_prev = 8'hFE;
      step("R6 prev chain"); check("R6 in2 from previous LUT", 32'(cell_out), 32'hAA);
      i2_from_prev = 8'hFF;
      step("R6 bit0 ignored"); check("R6 select of cell 0 ignored", 32'(cell_out), 32'hAA);
      i2_from_prev = '0; lut_i2 = '0;

      // R3 / R7 / R8 / R9 / R10: register behaviour
      fill_cfg(mk(1, 1, 0, 0)); ce_in = 1'b0;
      step("R7 hold"); check("R7 enable low holds", 32'(cell_out), 32'h0);
      ce_in = 1'b1;
      step("R7 load"); check("R3 registered load", 32'(cell_out), 32'hFF);
      sr_used = 1'b1; sr_in = 1'b1; ce_in = 1'b0;
      step("R9 no ce"); check("R9 sync needs enable", 32'(cell_out), 32'hFF);
      ce_in = 1'b1;
      step("R9 sync"); check("R9 sync reset", 32'(cell_out), 32'h0);
      sr_in = 1'b0;
      step("R9 release"); check("R9 reload after release", 32'(cell_out), 32'hFF);
      ce_in = 1'b0; fill_cfg(mk(1, 1, 0, 1));
      step("R10 prep");
      sr_in = 1'b1;
      step("R10 async"); check("R10 async reset without enable", 32'(cell_out), 32'h0);
      sr_in = 1'b0; ce_in = 1'b1;
      step("R10 release"); check("R10 reload", 32'(cell_out), 32'hFF);
      fill_cfg(mk(0, 1, 1, 0));
      step("R8 zeros"); check("R8 load zeros", 32'(cell_out), 32'h0);
      sr_in = 1'b1;
      step("R8 set"); check("R8 set value one", 32'(cell_out), 32'hFF);
      sr_used = 1'b0;
      step("R8 unused sr"); check("R8 unconnected set/reset ignored", 32'(cell_out), 32'h0);
      sr_in = 1'b0; ce_used = 1'b0; ce_in = 1'b0;
      fill_cfg(mk(1, 1, 0, 0));
      step("R7 default"); check("R7 unconnected enable reads one", 32'(cell_out), 32'hFF);
      fill_cfg(mk(0, 0, 0, 0));
      step("R3 bypass"); check("R3 bypass shows LUT", 32'(cell_out), 32'h0);

      // R11: falling-edge mode
      rst_n = 1'b0; fall_edge_mode = 1'b1; fill_cfg(mk(1, 1, 0, 0));
      step("R11 reset");
      rst_n = 1'b1;
      #2;
      check("R11 rising edge ignored", 32'(cell_out), 32'h0);
      step("R11 fall");
      check("R11 falling edge loads", 32'(cell_out), 32'hFF);
      rst_n = 1'b0; fall_edge_mode = 1'b0;
      step("R1 reset back");
      rst_n = 1'b1;

      // Random mix, all requirements through the model
      for (int s = 0; s < 1500; s++) begin
         if (s % 64 == 0) begin
            for (int i = 0; i < N; i++) cell_cfg[i*W +: W] = W'($urandom);
            sr_in = 1'b0;
         end else begin
            sr_in = ($urandom % 8) == 0;
         end
         lut_i0 = N'($urandom); lut_i1 = N'($urandom);
         lut_i2 = N'($urandom); lut_i3 = N'($urandom);
         i3_from_carry = N'($urandom); i2_from_prev = N'($urandom);
         ce_in = $urandom % 2; ce_used = $urandom % 2; sr_used = $urandom % 2;
         cin_from_below = $urandom % 2; cin_chain_en = $urandom % 2; cin_force = $urandom % 2;
         step("R2 R3 R4 R5 R6 R7 R8 R9 R10 random");
      end

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule